// File: doc/BRIEF.md
# Strobed Handshake Parallel Port Controller

This block drives two 8-bit parallel ports from a small register bus. Port C has input, output and per-bit direction control, plus a holding register that can capture the input pins. Port B is output only. An input strobe pin tells the block when peripheral data is valid or has been taken, and an output strobe pin acknowledges the peripheral. One shared event flag records each active input strobe edge. Software clears the flag with a fixed two-step access: a status read that sees the flag set, and then a data access to the port C holding register.

Three operating modes are selected from the control register: simple strobed, full input handshake and full output handshake. In the two handshake modes the output strobe is either a level acknowledge or a fixed-width pulse. In output handshake, port C is driven whenever the input strobe sits at its active level, so the peripheral can pull data on demand. The bus takes a register access in one cycle and never stalls, so it has no back-pressure. Read data is combinational from the address. All other pins are plain control and status pins with no valid/ready pairing.

Top module: `hsp_port_ctrl`

## Requirements
- R1: After reset, every register reads 0, port B and port C outputs are 0, port C direction outputs are 0 and the output strobe is low.
- R2: Register addresses are 0 = control/status, 1 = port C holding register, 2 = port B, 3 = port C direction. Control bits are: 7 event flag (read only), 6 handshake enable, 5 output-handshake select, 4 pulse select, 3 rising-edge select. Bits 2..0 read 0, and written bits 6..3 read back.
- R3: The input strobe passes through a two-flop synchronizer. Its active edge is falling when bit 3 is 0 and rising when bit 3 is 1. Every active edge sets the event flag in all modes, and the flag is visible three clock edges after the pin changes. Inactive edges leave the flag and the holding register unchanged.
- R4: In simple mode (bit 6 = 0) and in input handshake (bit 6 = 1, bit 5 = 0), the port C inputs are captured into the holding register on each active edge. In output handshake (bits 6 and 5 = 1) they are not captured.
- R5: In simple mode, a port B write updates port B and raises the output strobe (active high) for exactly two cycles.
- R6: In either handshake mode, a port B write updates port B and does not touch the output strobe.
- R7: In simple mode and input handshake, a status read that sees the flag set, followed by a read of the holding register, clears the flag.
- R8: In output handshake, the flag is cleared only when a status read that saw it set is followed by a write of the holding register. A read of the holding register leaves the flag set.
- R9: A data access that was not preceded by a status read that saw the flag set leaves the flag unchanged.
- R10: In output handshake, all port C direction outputs are 1 (drive) while the synchronized input strobe is at its active level (high if bit 3 = 1, low otherwise). At all other times, and in the other modes, they equal the direction register.
- R11: With handshake on and bit 4 = 0, the output strobe goes high when the holding register is read (input handshake) or written (output handshake). It stays high until the next active input strobe edge.
- R12: With handshake on and bit 4 = 1, the same trigger instead gives a strobe pulse exactly two cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C drive enables, 1 = drive |
| pb_out | output | 8 | Port B outputs |
| stra_in | input | 1 | Input strobe pin (asynchronous) |
| strb_out | output | 1 | Output strobe, active high |

## Verification
The assertions check several rules on every cycle. Each active edge must set the flag. The flag may only fall right after a holding-register access. A simple-mode port B write must give a strobe that is high for two cycles. The port C drive enables must follow the mode, the synchronized strobe level and the direction register. The bench scenarios check the parts that need a full sequence: the two-step clear in each mode, an unarmed access leaving the flag set, capture being suppressed in output handshake, and a level acknowledge that is held until the next active edge and not released by an inactive one.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PORTC = 2'd1;
  localparam logic [ADDR_W-1:0] A_PORTB = 2'd2;
  localparam logic [ADDR_W-1:0] A_DDRC  = 2'd3;

  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_HS   = 6;
  localparam int unsigned B_OUT  = 5;
  localparam int unsigned B_PLS  = 4;
  localparam int unsigned B_RISE = 3;

  typedef struct packed {
    logic hs;
    logic out_sel;
    logic pulse;
    logic rise;
  } cfg_t;
endpackage

// File: rtl/hsp_stra_sync.sv
module hsp_stra_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic act_edge,
  output logic act_level
);
  logic [STAGES-1:0] chain;
  logic              last;
  logic              synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign synced    = chain[STAGES-1];
  assign act_edge  = rise_sel ? (synced & ~last) : (~synced & last);
  assign act_level = rise_sel ? synced : ~synced;
endmodule

// File: rtl/hsp_flag.sv
module hsp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic act_edge,
  input  logic stat_rd,
  input  logic data_acc,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (act_edge) begin
        flag <= 1'b1;
      end else if (armed && data_acc) begin
        flag <= 1'b0;
      end
      if (stat_rd) begin
        armed <= flag;
      end else if (data_acc) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hsp_strobe.sv
module hsp_strobe #(
  parameter int unsigned PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic level_mode,
  input  logic simple_trig,
  input  logic hs_trig,
  input  logic act_edge,
  output logic strb
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic             lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else begin
      if (simple_trig || (hs_trig && pulse_mode)) begin
        cnt <= CNT_LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (!level_mode) begin
        lvl <= 1'b0;
      end else if (hs_trig) begin
        lvl <= 1'b1;
      end else if (act_edge) begin
        lvl <= 1'b0;
      end
    end
  end

  assign strb = (cnt != '0) | lvl;
endmodule

// File: rtl/hsp_port_ctrl.sv
module hsp_port_ctrl
  import hsp_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_oe,
  output logic [DATA_W-1:0] pb_out,
  input  logic              stra_in,
  output logic              strb_out
);
  cfg_t              cfg;
  logic [DATA_W-1:0] ddr_q;
  logic [DATA_W-1:0] pb_q;
  logic [DATA_W-1:0] pc_q;
  logic              act_edge;
  logic              act_level;
  logic              flag;
  logic              out_mode;
  logic              rd_pc, wr_pc, wr_pb, wr_ctrl, wr_ddr, rd_ctrl;
  logic              data_acc;

  assign out_mode = cfg.hs & cfg.out_sel;
  assign rd_ctrl  = bus_sel & ~bus_wr & (bus_addr == A_CTRL);
  assign rd_pc    = bus_sel & ~bus_wr & (bus_addr == A_PORTC);
  assign wr_ctrl  = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  assign wr_pc    = bus_sel &  bus_wr & (bus_addr == A_PORTC);
  assign wr_pb    = bus_sel &  bus_wr & (bus_addr == A_PORTB);
  assign wr_ddr   = bus_sel &  bus_wr & (bus_addr == A_DDRC);
  assign data_acc = out_mode ? wr_pc : rd_pc;

  hsp_stra_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin(stra_in), .rise_sel(cfg.rise),
    .act_edge(act_edge), .act_level(act_level)
  );

  hsp_flag flag_i (
    .clk(clk), .rst_n(rst_n), .act_edge(act_edge), .stat_rd(rd_ctrl),
    .data_acc(data_acc), .flag(flag)
  );

  hsp_strobe #(.PULSE_CYCLES(PULSE_CYCLES)) strobe_i (
    .clk(clk), .rst_n(rst_n), .pulse_mode(cfg.pulse),
    .level_mode(cfg.hs & ~cfg.pulse), .simple_trig(~cfg.hs & wr_pb),
    .hs_trig(cfg.hs & data_acc), .act_edge(act_edge), .strb(strb_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      ddr_q <= '0;
      pb_q  <= '0;
      pc_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg <= '{hs: bus_wdata[B_HS], out_sel: bus_wdata[B_OUT],
                 pulse: bus_wdata[B_PLS], rise: bus_wdata[B_RISE]};
      end
      if (wr_ddr) ddr_q <= bus_wdata;
      if (wr_pb)  pb_q  <= bus_wdata;
      if (wr_pc) begin
        pc_q <= bus_wdata;
      end else if (act_edge && !out_mode) begin
        pc_q <= pc_in;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_FLAG] = flag;
        bus_rdata[B_HS]   = cfg.hs;
        bus_rdata[B_OUT]  = cfg.out_sel;
        bus_rdata[B_PLS]  = cfg.pulse;
        bus_rdata[B_RISE] = cfg.rise;
      end
      A_PORTC: bus_rdata = pc_q;
      A_PORTB: bus_rdata = pb_q;
      default: bus_rdata = ddr_q;
    endcase
  end

  assign pc_out = pc_q;
  assign pb_out = pb_q;
  assign pc_oe  = (out_mode && act_level) ? '1 : ddr_q;
endmodule

// File: rtl/hsp_port_chk.sv
module hsp_port_chk
  import hsp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              act_edge,
  input logic              act_level,
  input logic              flag,
  input logic              strb_out,
  input cfg_t              cfg,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] pc_oe,
  input logic [DATA_W-1:0] ddr_q
);
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> flag);

  // R7, R8 and R9: the flag may only drop right after a holding-register access
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(bus_sel && (bus_addr == A_PORTC)));

  p_simple_strb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.hs && bus_sel && bus_wr && (bus_addr == A_PORTB)) |=> strb_out ##1 strb_out);

  p_drive_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hs && cfg.out_sel && act_level) |-> (pc_oe == '1));

  p_drive_ddr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg.hs && cfg.out_sel) |-> (pc_oe == ddr_q));
endmodule

bind hsp_port_ctrl hsp_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .act_edge(act_edge), .act_level(act_level),
  .flag(flag), .strb_out(strb_out), .cfg(cfg), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .pc_oe(pc_oe), .ddr_q(ddr_q)
);

// File: tb/hsp_port_ctrl_tb.sv
module hsp_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pc_in = 8'h00;
  logic [7:0] pc_out, pc_oe, pb_out;
  logic       stra_in = 1'b0;
  logic       strb_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  hsp_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .pb_out(pb_out),
    .stra_in(stra_in), .strb_out(strb_out)
  );

  task automatic expect_item(input string tag, input logic [7:0] e);
    exp_t it;
    it.tag = tag;
    it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic observe(input logic [7:0] act);
    exp_t it;
    checks++;
    if (sbq.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty: got=%02h expected=none", act);
    end else begin
      it = sbq.pop_front();
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] e);
    expect_item(tag, e);
    observe(act);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic set_stra(input logic v);
    @(negedge clk);
    stra_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): got=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 portc", d, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 strb", {7'd0, strb_out}, 8'h00);

    // R10 / R2 direction register in simple mode
    wr(2'd3, 8'h0F);
    rd(2'd3, d); chk("R2 ddr readback", d, 8'h0F);
    chk("R10 simple oe", pc_oe, 8'h0F);

    // R3 falling edge active by default, R4 capture, R7 clear
    pc_in = 8'hA5;
    set_stra(1'b1);
    rd(2'd0, d); chk("R3 inactive rise", d, 8'h00);
    rd(2'd1, d); chk("R4 no capture inactive", d, 8'h00);
    set_stra(1'b0);
    rd(2'd0, d); chk("R3 falling sets flag", d, 8'h80);
    rd(2'd1, d); chk("R4 capture", d, 8'hA5);
    rd(2'd0, d); chk("R7 cleared", d, 8'h00);

    // R9 unarmed access; rising edge select
    wr(2'd0, 8'h08);
    pc_in = 8'h3C;
    set_stra(1'b1);
    rd(2'd1, d); chk("R4 rising capture", d, 8'h3C);
    rd(2'd0, d); chk("R9 flag kept", d, 8'h88);
    rd(2'd1, d);
    rd(2'd0, d); chk("R7 clear after arm", d, 8'h08);

    // R5 simple strobe pulse
    wr(2'd2, 8'h5A);
    chk("R5 strb c1", {7'd0, strb_out}, 8'h01);
    chk("R5 pb_out", pb_out, 8'h5A);
    @(negedge clk); chk("R5 strb c2", {7'd0, strb_out}, 8'h01);
    @(negedge clk); chk("R5 strb end", {7'd0, strb_out}, 8'h00);

    // Input handshake, level acknowledge
    wr(2'd0, 8'h48);
    set_stra(1'b0);
    wr(2'd2, 8'h11);
    chk("R6 pb_out", pb_out, 8'h11);
    chk("R6 no strb", {7'd0, strb_out}, 8'h00);
    repeat (2) @(negedge clk);
    chk("R6 no strb later", {7'd0, strb_out}, 8'h00);
    pc_in = 8'h77;
    set_stra(1'b1);
    rd(2'd0, d); chk("R3 hs flag", d, 8'hC8);
    rd(2'd1, d); chk("R4 hs capture", d, 8'h77);
    chk("R11 level on read", {7'd0, strb_out}, 8'h01);
    set_stra(1'b0);
    chk("R11 held on inactive edge", {7'd0, strb_out}, 8'h01);
    set_stra(1'b1);
    chk("R11 released on active edge", {7'd0, strb_out}, 8'h00);
    rd(2'd0, d); rd(2'd1, d);

    // R12 pulse acknowledge in input handshake
    wr(2'd0, 8'h58);
    repeat (3) @(negedge clk);
    chk("R12 idle", {7'd0, strb_out}, 8'h00);
    rd(2'd1, d);
    chk("R12 pulse c1", {7'd0, strb_out}, 8'h01);
    @(negedge clk); chk("R12 pulse c2", {7'd0, strb_out}, 8'h01);
    @(negedge clk); chk("R12 pulse end", {7'd0, strb_out}, 8'h00);

    // Output handshake, level acknowledge
    wr(2'd0, 8'h68);
    @(negedge clk);
    chk("R10 drive at active level", pc_oe, 8'hFF);
    set_stra(1'b0);
    chk("R10 ddr at idle level", pc_oe, 8'h0F);
    pc_in = 8'h99;
    set_stra(1'b1);
    chk("R10 drive again", pc_oe, 8'hFF);
    rd(2'd1, d); chk("R4 no capture in output hs", d, 8'h77);
    rd(2'd0, d); chk("R8 flag set", d, 8'hE8);
    rd(2'd1, d);
    rd(2'd0, d); chk("R8 read does not clear", d, 8'hE8);
    wr(2'd1, 8'h42);
    chk("R11 level on write", {7'd0, strb_out}, 8'h01);
    chk("R8 pc_out", pc_out, 8'h42);
    rd(2'd0, d); chk("R8 write clears", d, 8'h68);
    set_stra(1'b0);
    chk("R11 out held", {7'd0, strb_out}, 8'h01);
    set_stra(1'b1);
    chk("R11 out released", {7'd0, strb_out}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule